// File: doc/BRIEF.md
# Sized Add/Subtract Flag ALU

This block is the arithmetic core of a condition-code processor. It performs addition, subtraction and comparison on byte, word or long operands and produces the size-clipped result together with five condition flags: carry (C), overflow (V), zero (Z), negative (N) and extend (X). The caller supplies two operands, a size code, an operation code, an extend-mode bit and the current X and Z flags. The block returns the result and the flags that follow from it.

Both operands are masked to the selected width before any arithmetic. Carry and overflow are then derived from three bit vectors: the internal carries, the overflow pattern and the result. Multi-precision arithmetic is supported by extend mode. In that mode, addition and subtraction bring in the incoming X flag, and the zero flag only stays set while every chunk of a wide value comes out zero.

A parameter chooses between a purely combinational output and a single register stage. The register stage is the default. With it, every output follows its inputs after exactly one clock edge, and reset clears all outputs.

Top module: `addsub_flag_alu`

## Requirements
- R1: Both operands are masked to the size chosen by sizeSel before use: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the size have no effect on any output.
- R2: Every bit of result above the selected size is zero.
- R3: opSel 0 adds (target + source). opSel 1 subtracts (target − source). opSel 2 and 3 compare, which is a subtraction. When extMode is 1, add also adds xIn and subtract also subtracts xIn. Compare never uses xIn.
- R4: flagC is bit (size−1) of (carry vector XOR overflow vector). The carry vector is target XOR source XOR raw result. For add, C equals the unsigned carry out. For subtract and compare, C equals the unsigned borrow.
- R5: flagV is bit (size−1) of the overflow vector. For add the overflow vector is (target XOR result) AND (source XOR result). For subtract and compare it is (target XOR result) AND (source XOR target). V equals signed overflow.
- R6: flagN equals the top bit of the clipped result at the selected size.
- R7: Outside extend mode, and always for compare, flagZ is 1 when the clipped result is zero and 0 otherwise.
- R8: In extend mode, for add or subtract, a zero result copies zIn to flagZ and a nonzero result clears flagZ.
- R9: For add and subtract, flagX equals the new flagC. For compare, flagX equals xIn.
- R10: With the default register stage, all outputs reflect the inputs present at the previous rising clock edge. While rstN is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low synchronous reset of the output stage |
| srcIn | input | 32 | Source operand |
| dstIn | input | 32 | Target operand |
| sizeSel | input | 2 | 0 byte, 1 word, 2 or 3 long |
| opSel | input | 2 | 0 add, 1 subtract, 2 or 3 compare |
| extMode | input | 1 | Extend mode for add and subtract |
| xIn | input | 1 | Current extend flag |
| zIn | input | 1 | Current zero flag |
| result | output | 32 | Clipped result, upper bits zero |
| flagC | output | 1 | Carry or borrow |
| flagV | output | 1 | Signed overflow |
| flagZ | output | 1 | Zero |
| flagN | output | 1 | Negative |
| flagX | output | 1 | Extend |

## Verification
The bench sweeps every byte source value against a spread of target values. It covers all operations, both extend modes and both incoming X values, and it fills the operand bits above the byte with garbage. A block that skipped operand clipping, or took carry from bit 32 instead of the size MSB, would then report wrong C and N flags for byte and word operations. Word and long operands are swept with pseudo-random values plus the signed and unsigned boundaries (0x7F.., 0x80.., all ones, zero), where a wrong overflow vector for subtract shows up as a wrong V. Extend-mode zero chains with zIn set and cleared expose a Z flag that is set instead of held. Compare with xIn set and extMode set exposes a compare that uses or updates X.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_CMP = 2'd2,
    OP_CMP_ALT = 2'd3
  } aluOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LONG_ALT = 2'd3
  } aluSize_e;

  typedef struct packed {
    logic [DATA_W-1:0] sizeMask;
    logic [DATA_W-1:0] msbMask;
    logic              subtract;
    logic              addExtend;
    logic              stickyZero;
    logic              updateX;
  } aluStrobes_t;

  function automatic logic [DATA_W-1:0] lowOnes(input int width);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < width);
    return m;
  endfunction
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0]  sizeSel,
  input  logic [1:0]  opSel,
  input  logic        extMode,
  output aluStrobes_t strobes
);
  localparam logic [DATA_W-1:0] MASK_B = lowOnes(BYTE_W);
  localparam logic [DATA_W-1:0] MASK_W = lowOnes(WORD_W);
  localparam logic [DATA_W-1:0] MASK_L = lowOnes(DATA_W);

  aluOp_e   opCode;
  aluSize_e szCode;
  logic     isCompare;

  assign opCode = aluOp_e'(opSel);
  assign szCode = aluSize_e'(sizeSel);

  always_comb begin
    unique case (szCode)
      SZ_BYTE: strobes.sizeMask = MASK_B;
      SZ_WORD: strobes.sizeMask = MASK_W;
      default: strobes.sizeMask = MASK_L;
    endcase
    strobes.msbMask = strobes.sizeMask ^ (strobes.sizeMask >> 1);
  end

  always_comb begin
    isCompare          = (opCode == OP_CMP) || (opCode == OP_CMP_ALT);
    strobes.subtract   = (opCode != OP_ADD);
    strobes.addExtend  = extMode && !isCompare;
    strobes.stickyZero = extMode && !isCompare;
    strobes.updateX    = !isCompare;
  end

  always_comb begin
    if (!$isunknown(opSel)) begin
      AST_MSB_ONEHOT: assert ($onehot0(strobes.msbMask) && strobes.msbMask != '0); // R4
      AST_CMP_NO_EXT: assert (!(opSel[1] && (strobes.addExtend || strobes.updateX))); // R9
    end
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
(
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] dstIn,
  input  logic              xIn,
  input  logic              zIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              cOut,
  output logic              vOut,
  output logic              zOut,
  output logic              nOut,
  output logic              xOut
);
  logic [DATA_W-1:0] srcClip;
  logic [DATA_W-1:0] dstClip;
  logic [DATA_W-1:0] extTerm;
  logic [DATA_W-1:0] rawSum;
  logic [DATA_W-1:0] carryVec;
  logic [DATA_W-1:0] ovfVec;
  logic              resIsZero;

  assign srcClip = srcIn & strobes.sizeMask;
  assign dstClip = dstIn & strobes.sizeMask;
  assign extTerm = {{(DATA_W-1){1'b0}}, strobes.addExtend & xIn};

  always_comb begin
    if (strobes.subtract) rawSum = dstClip - srcClip - extTerm;
    else                  rawSum = dstClip + srcClip + extTerm;
  end

  always_comb begin
    carryVec = dstClip ^ srcClip ^ rawSum;
    if (strobes.subtract) ovfVec = (dstClip ^ rawSum) & (srcClip ^ dstClip);
    else                  ovfVec = (dstClip ^ rawSum) & (srcClip ^ rawSum);
  end

  assign resultOut = rawSum & strobes.sizeMask;
  assign resIsZero = (resultOut == '0);
  assign cOut      = |((carryVec ^ ovfVec) & strobes.msbMask);
  assign vOut      = |(ovfVec & strobes.msbMask);
  assign nOut      = |(resultOut & strobes.msbMask);
  assign xOut      = strobes.updateX ? cOut : xIn;

  always_comb begin
    if (!resIsZero)             zOut = 1'b0;
    else if (strobes.stickyZero) zOut = zIn;
    else                        zOut = 1'b1;
  end

  always_comb begin
    if (!$isunknown({srcIn, dstIn, xIn, zIn, strobes})) begin
      AST_UPPER_ZERO: assert ((resultOut & ~strobes.sizeMask) == '0); // R2
      AST_NONZERO_CLEARS_Z: assert (resIsZero || !zOut); // R7
      AST_PLAIN_ZERO_SETS_Z: assert (strobes.stickyZero || !resIsZero || zOut); // R7
      AST_X_TRACKS_C: assert (!strobes.updateX || (xOut == cOut)); // R9
      AST_CMP_HOLDS_X: assert (strobes.updateX || (xOut == xIn)); // R9
      AST_ZERO_NOT_NEG: assert (!(resIsZero && nOut)); // R6
    end
  end
endmodule

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu
  import alu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [1:0]        sizeSel,
  input  logic [1:0]        opSel,
  input  logic              extMode,
  input  logic              xIn,
  input  logic              zIn,
  output logic [DATA_W-1:0] result,
  output logic              flagC,
  output logic              flagV,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagX
);
  aluStrobes_t       strobes;
  logic [DATA_W-1:0] nextRes;
  logic              nextC, nextV, nextZ, nextN, nextX;

  alu_ctrl u_ctrl (
    .sizeSel (sizeSel),
    .opSel   (opSel),
    .extMode (extMode),
    .strobes (strobes)
  );

  alu_datapath u_dp (
    .strobes   (strobes),
    .srcIn     (srcIn),
    .dstIn     (dstIn),
    .xIn       (xIn),
    .zIn       (zIn),
    .resultOut (nextRes),
    .cOut      (nextC),
    .vOut      (nextV),
    .zOut      (nextZ),
    .nOut      (nextN),
    .xOut      (nextX)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          result <= '0;
          flagC  <= 1'b0;
          flagV  <= 1'b0;
          flagZ  <= 1'b0;
          flagN  <= 1'b0;
          flagX  <= 1'b0;
        end else begin
          result <= nextRes;
          flagC  <= nextC;
          flagV  <= nextV;
          flagZ  <= nextZ;
          flagN  <= nextN;
          flagX  <= nextX;
        end
      end

      AST_CMP_X_REG: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) && $past(opSel[1]) |-> flagX == $past(xIn)); // R9
    end else begin : g_comb
      always_comb begin
        result = nextRes;
        flagC  = nextC;
        flagV  = nextV;
        flagZ  = nextZ;
        flagN  = nextN;
        flagX  = nextX;
      end
    end
  endgenerate
endmodule

// File: tb/addsub_flag_alu_test.sv
module addsub_flag_alu_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0, dstIn = '0;
  logic [1:0]  sizeSel = '0, opSel = '0;
  logic        extMode = 1'b0, xIn = 1'b0, zIn = 1'b0;
  logic [31:0] result;
  logic        flagC, flagV, flagZ, flagN, flagX;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  addsub_flag_alu uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .dstIn(dstIn),
    .sizeSel(sizeSel), .opSel(opSel), .extMode(extMode), .xIn(xIn), .zIn(zIn),
    .result(result), .flagC(flagC), .flagV(flagV), .flagZ(flagZ),
    .flagN(flagN), .flagX(flagX)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (op %0d size %0d ext %0d src %h dst %h x %0d z %0d)",
               req, act, exp, opSel, sizeSel, extMode, srcIn, dstIn, xIn, zIn);
    end
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  task automatic runVec(input logic [1:0] op, input logic [1:0] sz, input logic ext,
                        input logic [31:0] s, input logic [31:0] d,
                        input logic xi, input logic zi);
    int     width;
    longint modv, half, sv, tv, xe, full, res, ss, ts, sr;
    logic   expC, expV, expZ, expN, expX, isCmp;
    @(negedge clk);
    opSel = op; sizeSel = sz; extMode = ext; srcIn = s; dstIn = d; xIn = xi; zIn = zi;
    width = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    modv = longint'(1) << width;
    half = modv >> 1;
    sv = longint'(s) & (modv - 1);
    tv = longint'(d) & (modv - 1);
    isCmp = op[1];
    xe = (ext && !isCmp && xi) ? 1 : 0;
    ss = (sv >= half) ? sv - modv : sv;
    ts = (tv >= half) ? tv - modv : tv;
    if (op == 2'd0) begin
      full = tv + sv + xe; expC = (full >= modv); sr = ts + ss + xe;
    end else begin
      full = tv - sv - xe; expC = (full < 0); sr = ts - ss - xe;
    end
    res  = full & (modv - 1);
    expV = (sr < -half) || (sr >= half);
    expN = (res >= half);
    if (res != 0) expZ = 1'b0;
    else if (ext && !isCmp) expZ = zi;
    else expZ = 1'b1;
    expX = isCmp ? xi : expC;
    @(posedge clk);
    #1;
    chk("R1/R3 result", longint'(result), res);
    chk("R4 carry", longint'(flagC), longint'(expC));
    chk("R5 overflow", longint'(flagV), longint'(expV));
    chk("R6 negative", longint'(flagN), longint'(expN));
    chk((ext && !isCmp) ? "R8 zero sticky" : "R7 zero", longint'(flagZ), longint'(expZ));
    chk("R9 extend", longint'(flagX), longint'(expX));
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] edges [8];
    edges = '{32'h0, 32'h1, 32'h7F, 32'h80, 32'hFF, 32'h7FFF, 32'h8000, 32'hFFFF};

    srcIn = 32'hFFFF_FFFF; dstIn = 32'h1; opSel = 2'd1; xIn = 1'b1; zIn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset result", longint'(result), 0);
    chk("R10 reset flags", longint'({flagC, flagV, flagZ, flagN, flagX}), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R10 latency: output holds previous vector until the next edge
    runVec(2'd0, 2'd2, 1'b0, 32'h5, 32'h3, 1'b0, 1'b0);
    @(negedge clk);
    srcIn = 32'h10; dstIn = 32'h20;
    #1;
    chk("R10 latency hold", longint'(result), 8);
    @(posedge clk);
    #1;
    chk("R10 latency update", longint'(result), 32'h30);

    // R2: garbage above byte size must vanish from result
    runVec(2'd0, 2'd0, 1'b0, 32'hABCD_EF01, 32'h1234_56FF, 1'b0, 1'b0);
    chk("R2 upper zero", longint'(result >> 8), 0);

    // R8: extend zero chain keeps incoming Z
    runVec(2'd0, 2'd1, 1'b1, 32'hFFFF, 32'h0, 1'b1, 1'b0);
    runVec(2'd1, 2'd2, 1'b1, 32'h0, 32'h1, 1'b1, 1'b1);
    runVec(2'd2, 2'd0, 1'b1, 32'h5, 32'h5, 1'b1, 1'b0);
    runVec(2'd3, 2'd3, 1'b1, 32'h1, 32'h0, 1'b0, 1'b1);

    // Byte sweep with garbage upper bits: R1..R9
    for (int s = 0; s < 256; s++) begin
      for (int d = 0; d < 256; d += 17) begin
        for (int op = 0; op < 3; op++) begin
          for (int e = 0; e < 2; e++) begin
            runVec(op[1:0], 2'd0, e[0], {24'hA5C3F0 ^ s[23:0], s[7:0]},
                   {24'h5A0F3C ^ d[23:0], d[7:0]}, s[0] ^ d[1], s[1] ^ d[0]);
          end
        end
      end
    end

    // Word and long boundary corners: R4 R5 R7 R8
    for (int sz = 1; sz < 4; sz++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          for (int op = 0; op < 4; op++) begin
            runVec(op[1:0], sz[1:0], i[0], edges[i] | (sz > 1 ? {edges[j][15:0], 16'h0} : 32'h0),
                   edges[j] | (sz > 1 ? {edges[i][15:0], 16'h0} : 32'hFFFF_0000), j[0], i[1]);
          end
        end
      end
    end

    // Pseudo-random word and long
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a, b;
      seed = nextRand(seed); a = seed;
      seed = nextRand(seed); b = seed;
      runVec(a[1:0], {1'b0, 1'b1} + {1'b0, b[0]}, a[2], a, b, a[3], b[3]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule